// File: doc/BRIEF.md
# Integer ALU with sticky overflow flags

This block is a 32-bit fixed-point execution unit for addition, subtraction, negation, bitwise logic and comparison. Each accepted operation takes effect on one rising clock edge. The block keeps three pieces of state:

- a result register;
- an exception register, which holds a carry flag, an overflow flag, a sticky summary-overflow flag and a small byte count;
- a condition register built from eight 4-bit fields.

Arithmetic and logic operations can also record a signed view of their result, together with the current summary overflow, into condition field 0. Compares write their outcome into any field chosen by the caller.

The overflow flag is written only by arithmetic operations issued with overflow-enable set. The carry flag is written only by the carrying and extended forms. Compares and logic operations leave both flags alone. Summary overflow collects every overflow that gets set. It clears only when software loads the exception register directly, or moves the top flag bits into a condition field. The move into a condition field clears those flags as it copies them.

Top module: `fxu_alu`

## Requirements
- R1: While rst_n is low, and at its release, result, the three flags, exc_reg and cond_reg all read zero.
- R2: Arithmetic produces the following values: add gives A+B; add-extended gives A+B+CA; subtract-from gives B-A; subtract-from-extended gives ~A+B+CA; negate gives ~A+1. The value appears on result one edge after the operation is accepted.
- R3: An arithmetic operation issued with ovf_en=1 sets OV when the carry into the MSB differs from the carry out of the MSB, and clears OV otherwise. With ovf_en=0 it leaves OV unchanged.
- R4: SO becomes 1 whenever an operation sets OV. It then stays 1 through every operation except the exception-register load and the flag move.
- R5: The carrying forms (add-carrying, add-extended, subtract-from-carrying, subtract-from-extended) set CA to the carry out of the MSB. Plain add, subtract-from and negate leave CA unchanged.
- R6: The logic operations compute their bitwise function: and, and-with-complement (A&~B), or, or-with-complement (A|~B), nor, nand, xor and equivalence (~(A^B)). They never change OV, CA or SO.
- R7: With rec_en=1, an arithmetic or logic operation writes cr0 as {LT,GT,EQ,SO}, with LT at bit 3. LT means the result is negative, GT means it is positive and non-zero, EQ means it is zero, and SO is the summary flag after the operation. With rec_en=0, cr0 is unchanged.
- R8: A signed or unsigned compare writes {A<B, A>B, A==B, SO} into field crf_sel, which occupies cond_reg[31-4*crf_sel -: 4]. A compare changes neither result nor any flag, and it ignores rec_en.
- R9: The exception-register load copies wr_data[31] to SO, wr_data[30] to OV, wr_data[29] to CA and wr_data[6:0] to the byte count. exc_reg reads {SO,OV,CA,22'b0,count}.
- R10: The flag move writes {SO,OV,CA,0} into field crf_sel, then clears SO, OV and CA while keeping the byte count.
- R11: With op_valid=0, no state changes.
- R12: The op_code values are: 0 add, 1 add-carrying, 2 add-extended, 3 subtract-from, 4 subtract-from-carrying, 5 subtract-from-extended, 6 negate, 7 and, 8 and-complement, 9 or, 10 or-complement, 11 nor, 12 nand, 13 xor, 14 equivalence, 15 signed compare, 16 unsigned compare, 17 exception-register load, 18 flag move. Codes 19 to 31 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation accepted on this edge |
| op_code | input | 5 | Operation select (see R12) |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| ovf_en | input | 1 | Allow arithmetic to update OV/SO |
| rec_en | input | 1 | Record result into cr0 |
| crf_sel | input | 3 | Target field for compares and flag move |
| wr_data | input | 32 | Value for the exception-register load |
| result | output | 32 | Last arithmetic/logic result |
| flag_ca | output | 1 | Carry flag |
| flag_ov | output | 1 | Overflow flag |
| flag_so | output | 1 | Sticky summary overflow |
| cr0 | output | 4 | Condition field 0 {LT,GT,EQ,SO} |
| cond_reg | output | 32 | All condition fields, field 0 in the top nibble |
| exc_reg | output | 32 | Exception register {SO,OV,CA,0,count} |

## Verification
A summary flag that is cleared by mistake, or never set, shows up on flag_so one edge after the offending operation. The next recorded operation also copies it into bit 0 of cr0, and the next compare copies it into the low bit of the field that compare writes. An OV or CA flag that a logic operation or a compare corrupts appears on exc_reg right after that edge. A wrong carry-in changes the result of the following extended operation. The reference model is stepped once per accepted operation and compared on every cycle, so each of these faults is caught within one clock of its cause.

// File: rtl/fxu_pkg.sv
package fxu_pkg;

   typedef enum logic [4:0] {
      OP_ADD   = 5'd0,
      OP_ADDC  = 5'd1,
      OP_ADDE  = 5'd2,
      OP_SUBF  = 5'd3,
      OP_SUBFC = 5'd4,
      OP_SUBFE = 5'd5,
      OP_NEG   = 5'd6,
      OP_AND   = 5'd7,
      OP_ANDC  = 5'd8,
      OP_OR    = 5'd9,
      OP_ORC   = 5'd10,
      OP_NOR   = 5'd11,
      OP_NAND  = 5'd12,
      OP_XOR   = 5'd13,
      OP_EQV   = 5'd14,
      OP_CMPS  = 5'd15,
      OP_CMPU  = 5'd16,
      OP_LDXR  = 5'd17,
      OP_MVFL  = 5'd18
   } fxu_op_e;

   localparam int FLD_W = 4;

   function automatic logic op_is_arith(fxu_op_e op);
      return (op == OP_ADD)  || (op == OP_ADDC)  || (op == OP_ADDE) ||
             (op == OP_SUBF) || (op == OP_SUBFC) || (op == OP_SUBFE) ||
             (op == OP_NEG);
   endfunction

   function automatic logic op_is_logic(fxu_op_e op);
      return (op == OP_AND) || (op == OP_ANDC) || (op == OP_OR)  ||
             (op == OP_ORC) || (op == OP_NOR)  || (op == OP_NAND) ||
             (op == OP_XOR) || (op == OP_EQV);
   endfunction

   function automatic logic op_sets_ca(fxu_op_e op);
      return (op == OP_ADDC) || (op == OP_ADDE) ||
             (op == OP_SUBFC) || (op == OP_SUBFE);
   endfunction

   function automatic logic op_is_cmp(fxu_op_e op);
      return (op == OP_CMPS) || (op == OP_CMPU);
   endfunction

endpackage

// File: rtl/fxu_adder.sv
module fxu_adder
   import fxu_pkg::*;
#(
   parameter int DW        = 32,
   parameter bit MSB_SPLIT = 1'b0
) (
   input  fxu_op_e         op,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   input  logic            ca_in,
   output logic [DW-1:0]   sum,
   output logic            c_out,
   output logic            ovf
);

   logic [DW-1:0] x, y;
   logic          cin;
   logic          c_msb;

   // operand conditioning: subtraction is ~A + B + 1
   always_comb begin
      x   = a;
      y   = b;
      cin = 1'b0;
      unique case (op)
         OP_ADD, OP_ADDC: begin x = a;  y = b;        cin = 1'b0;  end
         OP_ADDE:         begin x = a;  y = b;        cin = ca_in; end
         OP_SUBF, OP_SUBFC: begin x = ~a; y = b;      cin = 1'b1;  end
         OP_SUBFE:        begin x = ~a; y = b;        cin = ca_in; end
         OP_NEG:          begin x = ~a; y = '0;       cin = 1'b1;  end
         default:         begin x = a;  y = b;        cin = 1'b0;  end
      endcase
   end

   always_comb begin
      {c_out, sum} = {1'b0, x} + {1'b0, y} + {{DW{1'b0}}, cin};
   end

   generate
      if (MSB_SPLIT) begin : g_split
         // separate narrow adder yields the carry into the MSB directly
         logic [DW-1:0] low;
         logic [DW-2:0] unused_low;
         always_comb begin
            low        = {1'b0, x[DW-2:0]} + {1'b0, y[DW-2:0]} + {{(DW-1){1'b0}}, cin};
            c_msb      = low[DW-1];
            unused_low = low[DW-2:0];
         end
      end else begin : g_xor
         // recover carry into the MSB from the sum bit and the operand bits
         always_comb c_msb = sum[DW-1] ^ x[DW-1] ^ y[DW-1];
      end
   endgenerate

   assign ovf = c_out ^ c_msb;

endmodule

// File: rtl/fxu_logic.sv
module fxu_logic
   import fxu_pkg::*;
#(
   parameter int DW = 32
) (
   input  fxu_op_e       op,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [DW-1:0] y
);

   always_comb begin
      unique case (op)
         OP_AND:  y = a & b;
         OP_ANDC: y = a & ~b;
         OP_OR:   y = a | b;
         OP_ORC:  y = a | ~b;
         OP_NOR:  y = ~(a | b);
         OP_NAND: y = ~(a & b);
         OP_XOR:  y = a ^ b;
         OP_EQV:  y = ~(a ^ b);
         default: y = '0;
      endcase
   end

endmodule

// File: rtl/fxu_cmp.sv
module fxu_cmp
   import fxu_pkg::*;
#(
   parameter int DW = 32
) (
   input  logic             is_signed,
   input  logic [DW-1:0]    a,
   input  logic [DW-1:0]    b,
   input  logic             so,
   output logic [FLD_W-1:0] fld
);

   logic lt, gt, eq;

   always_comb begin
      eq = (a == b);
      if (is_signed) begin
         lt = $signed(a) < $signed(b);
      end else begin
         lt = a < b;
      end
      gt  = !lt && !eq;
      fld = {lt, gt, eq, so};
   end

endmodule

// File: rtl/fxu_xer.sv
module fxu_xer #(
   parameter int DW    = 32,
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ld_en,
   input  logic [DW-1:0]    ld_data,
   input  logic             clr_en,
   input  logic             ov_we,
   input  logic             ov_val,
   input  logic             ca_we,
   input  logic             ca_val,
   output logic             so_q,
   output logic             ov_q,
   output logic             ca_q,
   output logic [CNT_W-1:0] cnt_q,
   output logic             so_nx
);

   logic             ov_nx, ca_nx;
   logic [CNT_W-1:0] cnt_nx;
   logic             unused_ld;

   always_comb begin
      so_nx  = so_q;
      ov_nx  = ov_q;
      ca_nx  = ca_q;
      cnt_nx = cnt_q;
      if (ld_en) begin
         so_nx  = ld_data[DW-1];
         ov_nx  = ld_data[DW-2];
         ca_nx  = ld_data[DW-3];
         cnt_nx = ld_data[CNT_W-1:0];
      end else if (clr_en) begin
         so_nx = 1'b0;
         ov_nx = 1'b0;
         ca_nx = 1'b0;
      end else begin
         if (ov_we) begin
            ov_nx = ov_val;
            so_nx = so_q | ov_val;
         end
         if (ca_we) begin
            ca_nx = ca_val;
         end
      end
   end

   assign unused_ld = ^ld_data[DW-4:CNT_W];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         so_q  <= 1'b0;
         ov_q  <= 1'b0;
         ca_q  <= 1'b0;
         cnt_q <= '0;
      end else begin
         so_q  <= so_nx;
         ov_q  <= ov_nx;
         ca_q  <= ca_nx;
         cnt_q <= cnt_nx;
      end
   end

endmodule

// File: rtl/fxu_alu.sv
module fxu_alu
   import fxu_pkg::*;
#(
   parameter int DW        = 32,
   parameter int CNT_W     = 7,
   parameter int NUM_FLD   = 8,
   parameter bit MSB_SPLIT = 1'b0,
   localparam int SEL_W    = (NUM_FLD > 1) ? $clog2(NUM_FLD) : 1,
   localparam int CR_W     = NUM_FLD * FLD_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               op_valid,
   input  logic [4:0]         op_code,
   input  logic [DW-1:0]      opnd_a,
   input  logic [DW-1:0]      opnd_b,
   input  logic               ovf_en,
   input  logic               rec_en,
   input  logic [SEL_W-1:0]   crf_sel,
   input  logic [DW-1:0]      wr_data,
   output logic [DW-1:0]      result,
   output logic               flag_ca,
   output logic               flag_ov,
   output logic               flag_so,
   output logic [FLD_W-1:0]   cr0,
   output logic [CR_W-1:0]    cond_reg,
   output logic [DW-1:0]      exc_reg
);

   generate
      if (DW < CNT_W + 3) begin : g_bad_dw
         $error("fxu_alu: DW must leave room for three flags above the count");
      end
      if (NUM_FLD < 1) begin : g_bad_fld
         $error("fxu_alu: NUM_FLD must be at least 1");
      end
   endgenerate

   fxu_op_e op;
   assign op = fxu_op_e'(op_code);

   logic is_arith, is_logic, is_cmp, is_ldxr, is_mvfl;
   always_comb begin
      is_arith = op_valid && op_is_arith(op);
      is_logic = op_valid && op_is_logic(op);
      is_cmp   = op_valid && op_is_cmp(op);
      is_ldxr  = op_valid && (op == OP_LDXR);
      is_mvfl  = op_valid && (op == OP_MVFL);
   end

   // datapath
   logic [DW-1:0] sum, lgc;
   logic          c_out, ovf;
   logic          so_q, ov_q, ca_q, so_nx;
   logic [CNT_W-1:0] cnt_q;

   fxu_adder #(.DW(DW), .MSB_SPLIT(MSB_SPLIT)) u_add (
      .op    (op),
      .a     (opnd_a),
      .b     (opnd_b),
      .ca_in (ca_q),
      .sum   (sum),
      .c_out (c_out),
      .ovf   (ovf)
   );

   fxu_logic #(.DW(DW)) u_lgc (
      .op (op),
      .a  (opnd_a),
      .b  (opnd_b),
      .y  (lgc)
   );

   logic [FLD_W-1:0] cmp_fld;
   fxu_cmp #(.DW(DW)) u_cmp (
      .is_signed (op == OP_CMPS),
      .a         (opnd_a),
      .b         (opnd_b),
      .so        (so_q),
      .fld       (cmp_fld)
   );

   fxu_xer #(.DW(DW), .CNT_W(CNT_W)) u_xer (
      .clk     (clk),
      .rst_n   (rst_n),
      .ld_en   (is_ldxr),
      .ld_data (wr_data),
      .clr_en  (is_mvfl),
      .ov_we   (is_arith && ovf_en),
      .ov_val  (ovf),
      .ca_we   (op_valid && op_sets_ca(op)),
      .ca_val  (c_out),
      .so_q    (so_q),
      .ov_q    (ov_q),
      .ca_q    (ca_q),
      .cnt_q   (cnt_q),
      .so_nx   (so_nx)
   );

   // result register
   logic [DW-1:0] res_nx, res_q;
   assign res_nx = is_arith ? sum : lgc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_q <= '0;
      end else if (is_arith || is_logic) begin
         res_q <= res_nx;
      end
   end

   // condition fields
   logic [FLD_W-1:0] rec_fld, mv_fld;
   always_comb begin
      rec_fld = {res_nx[DW-1], !res_nx[DW-1] && (|res_nx), ~(|res_nx), so_nx};
      mv_fld  = {so_q, ov_q, ca_q, 1'b0};
   end

   logic [FLD_W-1:0] fld_q [NUM_FLD];

   generate
      for (genvar k = 0; k < NUM_FLD; k++) begin : g_fld
         logic             hit, we;
         logic [FLD_W-1:0] nx;
         always_comb begin
            hit = (is_cmp || is_mvfl) && (crf_sel == SEL_W'(k));
            nx  = is_cmp ? cmp_fld : mv_fld;
            we  = hit;
            if (!hit && (k == 0) && rec_en && (is_arith || is_logic)) begin
               nx = rec_fld;
               we = 1'b1;
            end
         end
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               fld_q[k] <= '0;
            end else if (we) begin
               fld_q[k] <= nx;
            end
         end
         assign cond_reg[CR_W-1-FLD_W*k -: FLD_W] = fld_q[k];
      end
   endgenerate

   assign result  = res_q;
   assign flag_ca = ca_q;
   assign flag_ov = ov_q;
   assign flag_so = so_q;
   assign cr0     = fld_q[0];
   assign exc_reg = {so_q, ov_q, ca_q, {(DW-3-CNT_W){1'b0}}, cnt_q};

endmodule

// File: rtl/fxu_alu_chk.sv
module fxu_alu_chk
   import fxu_pkg::*;
#(
   parameter int DW   = 32,
   parameter int CR_W = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic            op_valid,
   input logic [4:0]      op_code,
   input logic            ovf_en,
   input logic            rec_en,
   input logic [DW-1:0]   result,
   input logic            flag_ca,
   input logic            flag_ov,
   input logic            flag_so,
   input logic [3:0]      cr0,
   input logic [CR_W-1:0] cond_reg,
   input logic [DW-1:0]   exc_reg
);

   fxu_op_e op;
   assign op = fxu_op_e'(op_code);

   // R4
   so_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_so && !(op_valid && (op == OP_LDXR || op == OP_MVFL))) |=> flag_so);

   // R4
   ov_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_is_arith(op) && ovf_en) |=> (!flag_ov || flag_so));

   // R8
   cmp_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_is_cmp(op)) |=> ($stable(exc_reg) && $stable(result)));

   // R6
   logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op_is_logic(op)) |=> ($stable(flag_ov) && $stable(flag_ca) && $stable(flag_so)));

   // R10
   mvfl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && op == OP_MVFL) |=> (!flag_so && !flag_ov && !flag_ca));

   // R7
   rec_so_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && rec_en && (op_is_arith(op) || op_is_logic(op))) |=> (cr0[0] == flag_so));

   // R11
   idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> ($stable(result) && $stable(cond_reg) && $stable(exc_reg)));

endmodule

bind fxu_alu fxu_alu_chk #(.DW(DW), .CR_W(CR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .op_valid (op_valid),
   .op_code  (op_code),
   .ovf_en   (ovf_en),
   .rec_en   (rec_en),
   .result   (result),
   .flag_ca  (flag_ca),
   .flag_ov  (flag_ov),
   .flag_so  (flag_so),
   .cr0      (cr0),
   .cond_reg (cond_reg),
   .exc_reg  (exc_reg)
);

// File: tb/tb_fxu_alu.sv
`timescale 1ns/1ps
module tb_fxu_alu;
   import fxu_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [4:0]  op_code = '0;
   logic [31:0] opnd_a = '0, opnd_b = '0, wr_data = '0;
   logic        ovf_en = 1'b0, rec_en = 1'b0;
   logic [2:0]  crf_sel = '0;
   logic [31:0] result, cond_reg, exc_reg;
   logic        flag_ca, flag_ov, flag_so;
   logic [3:0]  cr0;

   always #4 clk = ~clk;

   fxu_alu dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .ovf_en(ovf_en), .rec_en(rec_en),
      .crf_sel(crf_sel), .wr_data(wr_data), .result(result),
      .flag_ca(flag_ca), .flag_ov(flag_ov), .flag_so(flag_so),
      .cr0(cr0), .cond_reg(cond_reg), .exc_reg(exc_reg)
   );

   int checks = 0, fails = 0;
   bit done = 0;

   // reference state
   logic [31:0] m_res = '0, m_cr = '0;
   bit          m_so = 0, m_ov = 0, m_ca = 0;
   logic [6:0]  m_cnt = '0;

   task automatic put_fld(int sel, logic [3:0] v);
      m_cr[31-4*sel -: 4] = v;
   endtask

   task automatic model(bit v, int op, logic [31:0] a, logic [31:0] b,
                        bit oe, bit rc, int sel, logic [31:0] wd);
      longint unsigned x, y, cin, s;
      longint sx;
      logic [31:0] r;
      bit wr = 0;
      if (!v) return;
      if (op <= 6) begin
         x = a; y = b; cin = 0;
         if (op == 2) cin = m_ca;
         if (op == 3 || op == 4) begin x = {32'b0, ~a}; cin = 1; end
         if (op == 5) begin x = {32'b0, ~a}; cin = m_ca; end
         if (op == 6) begin x = {32'b0, ~a}; y = 0; cin = 1; end
         s  = x + y + cin;
         r  = s[31:0];
         sx = longint'($signed(x[31:0])) + longint'($signed(y[31:0])) + longint'(cin);
         if (oe) begin
            m_ov = (sx > 64'sd2147483647) || (sx < -64'sd2147483648);
            if (m_ov) m_so = 1;
         end
         if (op == 1 || op == 2 || op == 4 || op == 5) m_ca = s[32];
         wr = 1;
      end else if (op <= 14) begin
         case (op)
            7:  r = a & b;
            8:  r = a & ~b;
            9:  r = a | b;
            10: r = a | ~b;
            11: r = ~(a | b);
            12: r = ~(a & b);
            13: r = a ^ b;
            default: r = ~(a ^ b);
         endcase
         wr = 1;
      end else if (op == 15) begin
         put_fld(sel, {$signed(a) < $signed(b), $signed(a) > $signed(b), a == b, m_so});
      end else if (op == 16) begin
         put_fld(sel, {a < b, a > b, a == b, m_so});
      end else if (op == 17) begin
         m_so = wd[31]; m_ov = wd[30]; m_ca = wd[29]; m_cnt = wd[6:0];
      end else if (op == 18) begin
         put_fld(sel, {m_so, m_ov, m_ca, 1'b0});
         m_so = 0; m_ov = 0; m_ca = 0;
      end
      if (wr) begin
         m_res = r;
         if (rc) put_fld(0, {r[31], !r[31] && r != 0, r == 0, m_so});
      end
   endtask

   task automatic compare(string tag);
      logic [31:0] ex;
      ex = {m_so, m_ov, m_ca, 22'b0, m_cnt};
      checks++;
      if (result !== m_res || cond_reg !== m_cr || exc_reg !== ex ||
          flag_so !== m_so || flag_ov !== m_ov || flag_ca !== m_ca || cr0 !== m_cr[31:28]) begin
         fails++;
         $display("FAIL %s: res=%h cr=%h exc=%h expected res=%h cr=%h exc=%h",
                  tag, result, cond_reg, exc_reg, m_res, m_cr, ex);
      end
   endtask

   // drive at negedge, model after posedge, compare at next negedge
   task automatic step(string tag, bit v, int op, logic [31:0] a, logic [31:0] b,
                       bit oe, bit rc, int sel, logic [31:0] wd);
      op_valid = v; op_code = 5'(op); opnd_a = a; opnd_b = b;
      ovf_en = oe; rec_en = rc; crf_sel = 3'(sel); wr_data = wd;
      @(posedge clk);
      model(v, op, a, b, oe, rc, sel, wd);
      @(negedge clk);
      op_valid = 0;
      compare(tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(8 * 20000);
      fails++;
      $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      compare("R1");
      rst_n = 1;
      @(negedge clk);
      compare("R1");

      // R2 arithmetic values
      step("R2", 1, 0, 32'd5, 32'd7, 0, 0, 0, 0);
      step("R2", 1, 3, 32'd3, 32'd10, 0, 0, 0, 0);
      step("R2", 1, 6, 32'd5, 32'd0, 0, 0, 0, 0);
      // R5 carry generation, plain add leaves carry
      step("R5", 1, 1, 32'hFFFF_FFFF, 32'd1, 0, 0, 0, 0);
      step("R5", 1, 0, 32'hFFFF_FFFF, 32'd2, 0, 0, 0, 0);
      step("R2", 1, 2, 32'd10, 32'd20, 0, 0, 0, 0);
      step("R5", 1, 4, 32'd1, 32'd0, 0, 0, 0, 0);
      step("R2", 1, 5, 32'd1, 32'd9, 0, 0, 0, 0);
      // R3 overflow rule and its enable
      step("R3", 1, 0, 32'h7FFF_FFFF, 32'd1, 0, 0, 0, 0);
      step("R3", 1, 0, 32'h7FFF_FFFF, 32'd1, 1, 0, 0, 0);
      step("R4", 1, 0, 32'd1, 32'd1, 1, 0, 0, 0);
      step("R3", 1, 6, 32'h8000_0000, 32'd0, 1, 0, 0, 0);
      step("R3", 1, 3, 32'd1, 32'h8000_0000, 1, 1, 0, 0);
      // R6 logic leaves flags
      for (int k = 7; k <= 14; k++) step("R6", 1, k, 32'hF0F0_1234, 32'h0FF0_5678, 1, 0, 0, 0);
      // R7 recording
      step("R7", 1, 0, 32'hFFFF_FFF0, 32'd1, 0, 1, 0, 0);
      step("R7", 1, 13, 32'h55, 32'h55, 0, 1, 0, 0);
      step("R7", 1, 9, 32'd0, 32'd4, 0, 1, 0, 0);
      step("R7", 1, 7, 32'hFFFF_FFFF, 32'h8000_0000, 0, 0, 0, 0);
      // R8 compares
      step("R8", 1, 15, 32'hFFFF_FFFF, 32'd1, 1, 1, 3, 0);
      step("R8", 1, 16, 32'hFFFF_FFFF, 32'd1, 1, 1, 4, 0);
      step("R8", 1, 15, 32'd9, 32'd9, 0, 0, 7, 0);
      step("R8", 1, 16, 32'd2, 32'd9, 0, 0, 0, 0);
      // R10 flag move
      step("R10", 1, 18, 0, 0, 0, 0, 5, 0);
      step("R10", 1, 18, 0, 0, 0, 0, 6, 0);
      // R9 exception-register load
      step("R9", 1, 17, 0, 0, 0, 0, 0, 32'h2000_0055);
      step("R9", 1, 17, 0, 0, 0, 0, 0, 32'hFFFF_FFFF);
      step("R9", 1, 17, 0, 0, 0, 0, 0, 32'h4000_0003);
      // R11 idle
      step("R11", 0, 0, 32'h7FFF_FFFF, 32'd1, 1, 1, 0, 32'hFFFF_FFFF);
      step("R11", 0, 18, 0, 0, 0, 0, 2, 0);
      // R12 unused codes
      for (int k = 19; k <= 31; k++) step("R12", 1, k, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 1, 1, 2, 32'hFFFF_FFFF);

      // mixed traffic, reference compared on every cycle
      for (int i = 0; i < 600; i++) begin
         int op;
         op = int'($urandom_range(0, 31));
         if (op > 18 && ($urandom_range(0, 3) != 0)) op = int'($urandom_range(0, 18));
         step("R12", ($urandom_range(0, 7) != 0), op,
              ($urandom_range(0, 3) == 0) ? 32'h7FFF_FFFF : 32'($urandom),
              ($urandom_range(0, 3) == 0) ? 32'h8000_0000 : 32'($urandom),
              bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
              int'($urandom_range(0, 7)), 32'($urandom));
      end
      finish_run();
   end

endmodule